// File: doc/BRIEF.md
# Cascaded Divider Setting Search Engine

This block finds the best setting for a clock divider chain in which the parent clock first passes through a pre-divider. It then passes through a fixed divide-by-ten stage, a power-of-two stage selected by N, and an integer stage that divides by M plus a fixed offset. A caller supplies a parent rate, a wanted rate, the pre-divider and the M offset, and pulses `start`. The engine then walks all 128 M/N settings. For each one it computes the output rate that the setting would produce. It keeps the setting that lands nearest the wanted rate without going over it.

The block is used in place of a software loop when a clock has to be retuned. One restoring divider is shared by every division in a search. The first two divisions happen once per search and produce the base quotient. Each of the 128 candidates then needs one further division of the shifted base by its M stage. Inputs are captured when the search starts. The result registers keep their value until the next accepted start.

Top module: `divsearch_top`

## Requirements
- R1: After reset, `busy` and `done` are low, and `resRate`, `resM` and `resN` are all zero.
- R2: The rate of a setting (M, N) is computed in this order, with each division truncating: `((parentRate / preDiv) / 10) >> N`, then divided by `(M + mOffset)`. M ranges over 0..15 and N over 0..7.
- R3: A setting whose rate exceeds `targetRate` is never chosen, so a finished result satisfies `resRate <= targetRate`.
- R4: A setting replaces the held best only when its distance to the target is strictly smaller. Settings are visited with M as the outer loop and N as the inner loop, so on a tie the setting visited first is kept.
- R5: The held best starts as rate 0 with M = 0 and N = 0. When no setting qualifies, this is the result, and a setting with rate 0 is never taken.
- R6: `start` is accepted only while `busy` is low. A `start` raised while `busy` is high changes neither the inputs in use nor the result.
- R7: `done` is high for exactly one cycle at the end of a search, and `busy` is low in the following cycle.
- R8: While the block is idle, `resRate`, `resM` and `resN` hold their values regardless of the data inputs, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a search when idle |
| parentRate | input | 32 | Parent clock rate |
| targetRate | input | 32 | Wanted output rate |
| preDiv | input | 8 | Pre-divider value, nonzero |
| mOffset | input | 8 | Offset added to M, nonzero |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| resRate | output | 32 | Achieved rate of the chosen setting |
| resM | output | 4 | Chosen M |
| resN | output | 3 | Chosen N |

## Verification
Two hand-worked cases are used. In the first, an exact hit exists only after a nearer-but-lower rate has been seen twice, which shows that an exact match wins and that an equal rate found later does not displace the held best. In the second, two settings give the same rate, which shows the visit order. A zero target and a target below every nonzero rate expose the default result. A target above every rate must return the fastest setting. A sweep of parent rates, pre-dividers, offsets and targets is checked against a bench model, together with a competing start during a search and the stability of the result while idle.

// File: rtl/divsearch_pkg.sv
package divsearch_pkg;
  localparam int RATE_W  = 32;
  localparam int FACT_W  = 8;
  localparam int M_W     = 4;
  localparam int N_W     = 3;
  localparam int DEC_DIV = 10;

  typedef enum logic [1:0] {
    SEL_PRE  = 2'd0,
    SEL_DEC  = 2'd1,
    SEL_CAND = 2'd2
  } opSel_e;

  typedef struct packed {
    logic   load;
    logic   divGo;
    opSel_e sel;
    logic   keepStage;
    logic   keepBase;
    logic   evalStep;
  } ctlStrobe_t;
endpackage

// File: rtl/divsearch_div.sv
module divsearch_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     quotR, remR, dvsR;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic [W:0]       trial;
  logic             ge;

  always_comb begin
    trial = {remR, quotR[W-1]};
    ge    = (trial >= {1'b0, dvsR});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotR   <= '0;
      remR    <= '0;
      dvsR    <= '0;
      cnt     <= '0;
      running <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        quotR   <= dividend;
        remR    <= '0;
        dvsR    <= divisor;
        cnt     <= '0;
        running <= 1'b1;
      end else if (running) begin
        remR  <= ge ? W'(trial - {1'b0, dvsR}) : trial[W-1:0];
        quotR <= {quotR[W-2:0], ge};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(W - 1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

  assign quot = quotR;
endmodule

// File: rtl/divsearch_dp.sv
module divsearch_dp
  import divsearch_pkg::*;
#(
  parameter int RW  = RATE_W,
  parameter int FW  = FACT_W,
  parameter int MW  = M_W,
  parameter int NW  = N_W,
  parameter int DEC = DEC_DIV
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctl,
  input  logic [RW-1:0] parentRate,
  input  logic [RW-1:0] targetRate,
  input  logic [FW-1:0] preDiv,
  input  logic [FW-1:0] mOffset,
  output logic          divDone,
  output logic          lastCand,
  output logic [RW-1:0] resRate,
  output logic [MW-1:0] resM,
  output logic [NW-1:0] resN
);
  localparam logic [MW-1:0] M_LAST = {MW{1'b1}};
  localparam logic [NW-1:0] N_LAST = {NW{1'b1}};

  logic [RW-1:0] parentR, targetR, stageR, baseR;
  logic [FW-1:0] preDivR, mOffR;
  logic [MW-1:0] mIdx;
  logic [NW-1:0] nIdx;
  logic [RW-1:0] opA, opB, quot;
  logic [RW-1:0] distCand, distBest;
  logic          accept;

  always_comb begin
    unique case (ctl.sel)
      SEL_PRE: begin
        opA = parentR;
        opB = RW'(preDivR);
      end
      SEL_DEC: begin
        opA = stageR;
        opB = RW'(DEC);
      end
      default: begin
        opA = baseR >> nIdx;
        opB = RW'(mIdx) + RW'(mOffR);
      end
    endcase
  end

  divsearch_div #(.W(RW)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (ctl.divGo),
    .dividend (opA),
    .divisor  (opB),
    .fin      (divDone),
    .quot     (quot)
  );

  always_comb begin
    distCand = targetR - quot;
    distBest = targetR - resRate;
    accept   = (quot <= targetR) && (distCand < distBest);
    lastCand = (mIdx == M_LAST) && (nIdx == N_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parentR <= '0;
      targetR <= '0;
      preDivR <= '0;
      mOffR   <= '0;
      stageR  <= '0;
      baseR   <= '0;
      mIdx    <= '0;
      nIdx    <= '0;
      resRate <= '0;
      resM    <= '0;
      resN    <= '0;
    end else begin
      if (ctl.load) begin
        parentR <= parentRate;
        targetR <= targetRate;
        preDivR <= preDiv;
        mOffR   <= mOffset;
        mIdx    <= '0;
        nIdx    <= '0;
        resRate <= '0;
        resM    <= '0;
        resN    <= '0;
      end
      if (ctl.keepStage) stageR <= quot;
      if (ctl.keepBase)  baseR  <= quot;
      if (ctl.evalStep) begin
        if (accept) begin
          resRate <= quot;
          resM    <= mIdx;
          resN    <= nIdx;
        end
        if (nIdx == N_LAST) begin
          nIdx <= '0;
          mIdx <= mIdx + 1'b1;
        end else begin
          nIdx <= nIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/divsearch_ctrl.sv
module divsearch_ctrl
  import divsearch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divDone,
  input  logic       lastCand,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done
);
  typedef enum logic [2:0] {
    S_IDLE, S_PRE_GO, S_PRE_WAIT, S_DEC_GO, S_DEC_WAIT,
    S_CAND_GO, S_CAND_WAIT, S_FINISH
  } state_e;

  state_e state, nxt;

  always_comb begin
    nxt = state;
    ctl = '0;
    ctl.sel = SEL_CAND;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.load = 1'b1;
        nxt = S_PRE_GO;
      end
      S_PRE_GO: begin
        ctl.sel   = SEL_PRE;
        ctl.divGo = 1'b1;
        nxt = S_PRE_WAIT;
      end
      S_PRE_WAIT: begin
        ctl.sel = SEL_PRE;
        if (divDone) begin
          ctl.keepStage = 1'b1;
          nxt = S_DEC_GO;
        end
      end
      S_DEC_GO: begin
        ctl.sel   = SEL_DEC;
        ctl.divGo = 1'b1;
        nxt = S_DEC_WAIT;
      end
      S_DEC_WAIT: begin
        ctl.sel = SEL_DEC;
        if (divDone) begin
          ctl.keepBase = 1'b1;
          nxt = S_CAND_GO;
        end
      end
      S_CAND_GO: begin
        ctl.divGo = 1'b1;
        nxt = S_CAND_WAIT;
      end
      S_CAND_WAIT: if (divDone) begin
        ctl.evalStep = 1'b1;
        nxt = lastCand ? S_FINISH : S_CAND_GO;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);
endmodule

// File: rtl/divsearch_top.sv
module divsearch_top
  import divsearch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [RATE_W-1:0] parentRate,
  input  logic [RATE_W-1:0] targetRate,
  input  logic [FACT_W-1:0] preDiv,
  input  logic [FACT_W-1:0] mOffset,
  output logic              busy,
  output logic              done,
  output logic [RATE_W-1:0] resRate,
  output logic [M_W-1:0]    resM,
  output logic [N_W-1:0]    resN
);
  ctlStrobe_t ctl;
  logic       divDone, lastCand;

  divsearch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .divDone  (divDone),
    .lastCand (lastCand),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  divsearch_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .parentRate (parentRate),
    .targetRate (targetRate),
    .preDiv     (preDiv),
    .mOffset    (mOffset),
    .divDone    (divDone),
    .lastCand   (lastCand),
    .resRate    (resRate),
    .resM       (resM),
    .resN       (resN)
  );
endmodule

// File: rtl/divsearch_chk.sv
module divsearch_chk
  import divsearch_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [RATE_W-1:0] targetRate,
  input logic              busy,
  input logic              done,
  input logic [RATE_W-1:0] resRate,
  input logic [M_W-1:0]    resM,
  input logic [N_W-1:0]    resN
);
  logic [RATE_W-1:0] tgtSeen;

  always_ff @(posedge clk) begin
    if (!rstN)               tgtSeen <= '0;
    else if (start && !busy) tgtSeen <= targetRate;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_rate_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (resRate <= tgtSeen));
  p_zero_default_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && resRate == '0) |-> (resM == '0 && resN == '0));
  p_start_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(resRate) && $stable(resM) && $stable(resN)));
endmodule

bind divsearch_top divsearch_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .targetRate (targetRate),
  .busy       (busy),
  .done       (done),
  .resRate    (resRate),
  .resM       (resM),
  .resN       (resN)
);

// File: tb/divsearch_top_tb.sv
`timescale 1ns/1ps
module divsearch_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parentRate = '0, targetRate = '0;
  logic [7:0]  preDiv = 8'd1, mOffset = 8'd1;
  logic        busy, done;
  logic [31:0] resRate;
  logic [3:0]  resM;
  logic [2:0]  resN;

  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;

  divsearch_top u_dut (
    .clk(clk), .rstN(rstN), .start(start), .parentRate(parentRate),
    .targetRate(targetRate), .preDiv(preDiv), .mOffset(mOffset),
    .busy(busy), .done(done), .resRate(resRate), .resM(resM), .resN(resN)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic refSearch(input [31:0] p, input [31:0] t, input [7:0] pd, input [7:0] mo,
                           output [31:0] r, output [3:0] bm, output [2:0] bn);
    logic [31:0] base, c;
    base = (p / pd) / 10;
    r = 0; bm = 0; bn = 0;
    for (int m = 0; m < 16; m++)
      for (int n = 0; n < 8; n++) begin
        c = (base >> n) / (m + mo);
        if (c <= t && (t - c) < (t - r)) begin
          r = c; bm = 4'(m); bn = 3'(n);
        end
      end
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic runOne(input [31:0] p, input [31:0] t, input [7:0] pd, input [7:0] mo,
                        input bool_disturb, input string tag);
    logic [31:0] er; logic [3:0] em; logic [2:0] en; bit ok;
    refSearch(p, t, pd, mo, er, em, en);
    @(negedge clk);
    parentRate = p; targetRate = t; preDiv = pd; mOffset = mo; start = 1;
    @(negedge clk);
    start = 0;
    check(busy, "R6 busy after start", busy, 1);
    if (bool_disturb) begin
      repeat (50) @(negedge clk);
      parentRate = ~p; targetRate = t ^ 32'h5555; preDiv = pd + 8'd3; mOffset = mo + 8'd2; start = 1;
      @(negedge clk);
      start = 0;
      check(busy, "R6 start while busy", busy, 1);
    end
    waitDone(ok);
    check(ok, "R7 done seen", ok, 1);
    check(resRate == er, {tag, " rate"}, resRate, er);
    check(resM == em, {tag, " M"}, resM, em);
    check(resN == en, {tag, " N"}, resN, en);
    @(negedge clk);
    check(!done && !busy, "R7 single done, idle after", {done, busy}, 0);
  endtask

  task automatic runHand(input [31:0] p, input [31:0] t, input [7:0] pd, input [7:0] mo,
                         input [31:0] er, input [3:0] em, input [2:0] en, input string tag);
    bit ok;
    @(negedge clk);
    parentRate = p; targetRate = t; preDiv = pd; mOffset = mo; start = 1;
    @(negedge clk);
    start = 0;
    waitDone(ok);
    check(resRate == er, {tag, " rate"}, resRate, er);
    check(resM == em, {tag, " M"}, resM, em);
    check(resN == en, {tag, " N"}, resN, en);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] p, t, hr; logic [3:0] hm; logic [2:0] hn;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1 flags", {busy, done}, 0);
    check(resRate == 0 && resM == 0 && resN == 0, "R1 result", resRate, 0);
    rstN = 1;
    // R2/R4 exact hit after repeated 75000: base 2400000, M=2 N=3 gives 100000
    runHand(32'd24_000_000, 32'd100_000, 8'd1, 8'd1, 32'd100_000, 4'd2, 3'd3, "R2 R4 exact");
    // R4 tie: base 1000, (M0,N1) and (M1,N0) both 500; first visited kept
    runHand(32'd10_000, 32'd500, 8'd1, 8'd1, 32'd500, 4'd0, 3'd1, "R4 tie");
    // R5 zero target and target below every nonzero rate
    runHand(32'd24_000_000, 32'd0, 8'd1, 8'd1, 32'd0, 4'd0, 3'd0, "R5 zero target");
    runHand(32'd200_000_000, 32'd100, 8'd1, 8'd4, 32'd0, 4'd0, 3'd0, "R5 none fits");
    // R3 target above everything: fastest setting M0 N0
    runHand(32'd300_000_000, 32'hFFFF_FFFF, 8'd3, 8'd1, 32'd10_000_000, 4'd0, 3'd0, "R3 max");
    // R8 stable while idle with changing inputs
    hr = resRate; hm = resM; hn = resN;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      parentRate = 32'(i * 977); targetRate = 32'(i * 31); preDiv = 8'(i + 1);
    end
    check(resRate == hr && resM == hm && resN == hn, "R8 idle hold", resRate, hr);
    // R6 competing start mid-search
    runOne(32'd297_000_000, 32'd400_000, 8'd2, 8'd1, 1, "R6 disturbed");
    // R2 R3 R4 sweep
    for (int k = 0; k < 12; k++) begin
      p = 32'd1_000_000 + 32'(k) * 32'd23_456_789;
      t = (p / 32'(10 * (k + 3))) + 32'(k * 131);
      runOne(p, t, 8'(1 + (k % 5)), 8'(1 + (k % 3)), 0, "R2 R3 sweep");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule